// File: doc/BRIEF.md
# Staged Memory-Subsystem Reset Sequencer

This block drives the reset lines of a memory subsystem built from a protocol controller and a PHY, where the PHY has an analog section and a digital section. On a start request it pulls every reset low at once. It then lets the lines go one at a time in a fixed order: the PHY line first, then the controller line, then the PHY analog line, then the PHY digital line. Each gap is a count of reference-clock cycles.

Four cycle counts are taken from configuration inputs and captured when a start is accepted. A zero count is raised to one. The analog-to-digital gap is never shorter than a parameterised minimum, which defaults to 1000 cycles. The controller and PHY lines are each a bundle of `LANES` active-low bits that always move together. A done flag rises one cycle after the last line is released and stays up until the next accepted start.

Top module: `mem_rst_sequencer`

## Requirements
- R1: While `rst_n` is low, and after it until a start is accepted, every reset output is low (asserted) and `done_o` is low.
- R2: A start is accepted when the block is idle or done. At the clock edge that samples it, every reset output goes low and `done_o` goes low.
- R3: The PHY bundle goes high P edges after the accepting edge, where P is `dly_phy_i` captured at that edge.
- R4: The controller bundle goes high C edges after the PHY release, where C is the captured `dly_ctl_i`.
- R5: The analog reset goes high A edges after the controller release, where A is the captured `dly_ana_i`.
- R6: The digital reset goes high G edges after the analog release, where G is the larger of the captured `dly_dig_i` and `MIN_DIG_GAP` (default 1000).
- R7: `done_o` rises exactly one edge after the digital release and holds until the next accepted start.
- R8: A start that arrives while the sequence is running has no effect on any output.
- R9: The delay inputs are sampled only at the accepting edge. Changing them later in the sequence has no effect.
- R10: A delay input of zero acts as a delay of one cycle.
- R11: All bits of the controller bundle are always equal, and all bits of the PHY bundle are always equal.
- R12: The controller is never released while the PHY is held, and the digital reset is never released while the analog reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| start_i | input | 1 | Request to run the sequence |
| dly_phy_i | input | CNT_W | Cycles from assertion to PHY release |
| dly_ctl_i | input | CNT_W | Cycles from PHY release to controller release |
| dly_ana_i | input | CNT_W | Cycles from controller release to analog release |
| dly_dig_i | input | CNT_W | Cycles from analog release to digital release (raised to the minimum) |
| ctl_rst_no | output | LANES | Controller reset bundle, active low |
| phy_rst_no | output | LANES | PHY reset bundle, active low |
| ana_rst_no | output | 1 | PHY analog reset, active low |
| dig_rst_no | output | 1 | PHY digital reset, active low |
| done_o | output | 1 | Sequence complete |

## Verification
All outputs are registered. After the accepting edge E, the PHY bundle is due at edge E+P, the controller at E+P+C, the analog line at E+P+C+A, and the digital line at E+P+C+A+G. `done_o` is due one edge after the digital line. The bench samples on the falling clock edge and numbers each sample by how many rising edges have passed since E. For each output it records the first sample at which the output is high and compares that number with the sum worked out from the clamped delays. At sample zero it checks that every line is asserted, and at every sample it checks that the bundle bits agree and that the release order holds.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WPHY,
      ST_WCTL,
      ST_WANA,
      ST_WDIG,
      ST_REL,
      ST_DONE
   } seq_state_e;

   // 1 = released (high on the pin), 0 = held in reset
   typedef struct packed {
      logic ctl;
      logic phy;
      logic ana;
      logic dig;
      logic done;
   } rel_vec_t;

   function automatic rel_vec_t state_outputs(input seq_state_e s);
      rel_vec_t v;
      v = '0;
      case (s)
         ST_WCTL: v.phy = 1'b1;
         ST_WANA: begin v.phy = 1'b1; v.ctl = 1'b1; end
         ST_WDIG: begin v.phy = 1'b1; v.ctl = 1'b1; v.ana = 1'b1; end
         ST_REL:  begin v.phy = 1'b1; v.ctl = 1'b1; v.ana = 1'b1; v.dig = 1'b1; end
         ST_DONE: begin v.phy = 1'b1; v.ctl = 1'b1; v.ana = 1'b1; v.dig = 1'b1; v.done = 1'b1; end
         default: v = '0;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/rstseq_cfg.sv
module rstseq_cfg #(
   parameter int CNT_W       = 16,
   parameter int MIN_DIG_GAP = 1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic [CNT_W-1:0] dly_phy,
   input  logic [CNT_W-1:0] dly_ctl,
   input  logic [CNT_W-1:0] dly_ana,
   input  logic [CNT_W-1:0] dly_dig,
   output logic [CNT_W-1:0] phy_now,
   output logic [CNT_W-1:0] ctl_q,
   output logic [CNT_W-1:0] ana_q,
   output logic [CNT_W-1:0] dig_q
);

   localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);
   localparam logic [CNT_W-1:0] GAP_C = CNT_W'(MIN_DIG_GAP);

   function automatic logic [CNT_W-1:0] at_least(input logic [CNT_W-1:0] v,
                                                  input logic [CNT_W-1:0] m);
      return (v < m) ? m : v;
   endfunction

   // R10: a zero count is raised to one; R6: digital gap has a floor
   assign phy_now = at_least(dly_phy, ONE_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= ONE_C;
         ana_q <= ONE_C;
         dig_q <= GAP_C;
      end else if (capture) begin
         ctl_q <= at_least(dly_ctl, ONE_C);
         ana_q <= at_least(dly_ana, ONE_C);
         dig_q <= at_least(dly_dig, GAP_C);
      end
   end

   // R9: the held values move only on a capture
   assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(ctl_q) && $stable(ana_q) && $stable(dig_q));

   assert_dig_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> dig_q >= GAP_C);

endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   // a load of N makes expired true N cycles later
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (load)            cnt_q <= load_val - CNT_W'(1);
      else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
   end

   assign expired = (cnt_q == '0);

   assert_load_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> load_val != '0);

   assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !expired) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
   import rstseq_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int MIN_DIG_GAP = 1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             expired,
   input  logic [CNT_W-1:0] phy_now,
   input  logic [CNT_W-1:0] ctl_q,
   input  logic [CNT_W-1:0] ana_q,
   input  logic [CNT_W-1:0] dig_q,
   output logic             accept,
   output logic             load,
   output logic [CNT_W-1:0] load_val,
   output rel_vec_t         vec_d,
   output rel_vec_t         vec_q
);

   seq_state_e state_q, state_d;

   assign accept = start && (state_q == ST_IDLE || state_q == ST_DONE);

   always_comb begin
      state_d  = state_q;
      load     = 1'b0;
      load_val = phy_now;
      case (state_q)
         ST_IDLE, ST_DONE: if (accept) begin
            state_d = ST_WPHY; load = 1'b1; load_val = phy_now;
         end
         ST_WPHY: if (expired) begin
            state_d = ST_WCTL; load = 1'b1; load_val = ctl_q;
         end
         ST_WCTL: if (expired) begin
            state_d = ST_WANA; load = 1'b1; load_val = ana_q;
         end
         ST_WANA: if (expired) begin
            state_d = ST_WDIG; load = 1'b1; load_val = dig_q;
         end
         ST_WDIG: if (expired) state_d = ST_REL;
         ST_REL:  state_d = ST_DONE;
         default: state_d = ST_IDLE;
      endcase
   end

   assign vec_d = state_outputs(state_d);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         vec_q   <= state_outputs(ST_IDLE);
      end else begin
         state_q <= state_d;
         vec_q   <= vec_d;
      end
   end

   // gap observer: cycles from analog release to digital release
   logic [CNT_W-1:0] gap_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         gap_cnt <= '0;
      else if (!vec_q.ana)                gap_cnt <= '0;
      else if (!vec_q.dig && gap_cnt != '1) gap_cnt <= gap_cnt + CNT_W'(1);
   end

   assert_dig_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vec_q.dig) |-> gap_cnt >= CNT_W'(MIN_DIG_GAP));

   assert_accept_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !vec_q.phy && !vec_q.ctl && !vec_q.done);

   assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !accept && state_q != ST_WPHY) |=> state_q != ST_WPHY);

   assert_done_after_dig_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vec_q.done) |-> $past(vec_q.dig));

   assert_order_ctl_R12: assert property (@(posedge clk) disable iff (!rst_n)
      vec_q.ctl |-> vec_q.phy);

   assert_order_dig_R12: assert property (@(posedge clk) disable iff (!rst_n)
      vec_q.dig |-> vec_q.ana);

endmodule

// File: rtl/mem_rst_sequencer.sv
module mem_rst_sequencer
   import rstseq_pkg::*;
#(
   parameter int LANES       = 2,
   parameter int CNT_W       = 16,
   parameter int MIN_DIG_GAP = 1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] dly_phy_i,
   input  logic [CNT_W-1:0] dly_ctl_i,
   input  logic [CNT_W-1:0] dly_ana_i,
   input  logic [CNT_W-1:0] dly_dig_i,
   output logic [LANES-1:0] ctl_rst_no,
   output logic [LANES-1:0] phy_rst_no,
   output logic             ana_rst_no,
   output logic             dig_rst_no,
   output logic             done_o
);

   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("CNT_W must lie in 2..32");
   end
   if (MIN_DIG_GAP < 1 || longint'(MIN_DIG_GAP) >= (longint'(1) << CNT_W)) begin : g_bad_gap
      $error("MIN_DIG_GAP must be nonzero and fit in CNT_W bits");
   end

   logic             accept, load, expired;
   logic [CNT_W-1:0] load_val, phy_now, ctl_q, ana_q, dig_q;
   rel_vec_t         vec_d, vec_q;

   rstseq_cfg #(.CNT_W(CNT_W), .MIN_DIG_GAP(MIN_DIG_GAP)) u_cfg (
      .clk(clk), .rst_n(rst_n), .capture(accept),
      .dly_phy(dly_phy_i), .dly_ctl(dly_ctl_i),
      .dly_ana(dly_ana_i), .dly_dig(dly_dig_i),
      .phy_now(phy_now), .ctl_q(ctl_q), .ana_q(ana_q), .dig_q(dig_q)
   );

   rstseq_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
      .expired(expired)
   );

   rstseq_ctrl #(.CNT_W(CNT_W), .MIN_DIG_GAP(MIN_DIG_GAP)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start_i), .expired(expired),
      .phy_now(phy_now), .ctl_q(ctl_q), .ana_q(ana_q), .dig_q(dig_q),
      .accept(accept), .load(load), .load_val(load_val),
      .vec_d(vec_d), .vec_q(vec_q)
   );

   // one flop per lane so each reset bit drives its own load
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctl_rst_no[i] <= 1'b0;
            phy_rst_no[i] <= 1'b0;
         end else begin
            ctl_rst_no[i] <= vec_d.ctl;
            phy_rst_no[i] <= vec_d.phy;
         end
      end
   end

   assign ana_rst_no = vec_q.ana;
   assign dig_rst_no = vec_q.dig;
   assign done_o     = vec_q.done;

   assert_lanes_ctl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ctl_rst_no) == 0 || $countones(ctl_rst_no) == LANES);

   assert_lanes_phy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(phy_rst_no) == 0 || $countones(phy_rst_no) == LANES);

   assert_lane_vs_core_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rst_no[0] |-> phy_rst_no[0]);

   assert_done_all_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (&ctl_rst_no) && (&phy_rst_no) && ana_rst_no && dig_rst_no);

endmodule

// File: tb/tb_mem_rst_sequencer.sv
module tb_mem_rst_sequencer;

   localparam int LANES = 2;
   localparam int CNT_W = 16;
   localparam int MING  = 1000;
   localparam logic [LANES-1:0] ALL1 = '1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [CNT_W-1:0] dly_phy_i = '0, dly_ctl_i = '0, dly_ana_i = '0, dly_dig_i = '0;
   logic [LANES-1:0] ctl_rst_no, phy_rst_no;
   logic ana_rst_no, dig_rst_no, done_o;

   always #5 clk = ~clk;

   mem_rst_sequencer #(.LANES(LANES), .CNT_W(CNT_W), .MIN_DIG_GAP(MING)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .dly_phy_i(dly_phy_i), .dly_ctl_i(dly_ctl_i),
      .dly_ana_i(dly_ana_i), .dly_dig_i(dly_dig_i),
      .ctl_rst_no(ctl_rst_no), .phy_rst_no(phy_rst_no),
      .ana_rst_no(ana_rst_no), .dig_rst_no(dig_rst_no), .done_o(done_o)
   );

   int checks = 0;
   int failures = 0;
   bit finished = 0;
   int t_phy, t_ctl, t_ana, t_dig, t_done;

   // stimulus vectors: phy, ctl, ana, dig delays
   localparam int VEC [4][4] = '{
      '{3, 5, 2, 1000},
      '{1, 1, 1, 1200},
      '{0, 0, 0, 0},
      '{7, 2, 9, 5}
   };

   function automatic int floor_of(input int v, input int m);
      return (v < m) ? m : v;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_seq(input int p, input int c, input int a, input int d,
                          input int inj, input bit chg);
      bit lane_bad = 0, order_bad = 0;
      t_phy = -1; t_ctl = -1; t_ana = -1; t_dig = -1; t_done = -1;
      dly_phy_i = CNT_W'(p); dly_ctl_i = CNT_W'(c);
      dly_ana_i = CNT_W'(a); dly_dig_i = CNT_W'(d);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      // R2: the accepting edge asserts everything
      check(ctl_rst_no == '0 && phy_rst_no == '0 && !ana_rst_no && !dig_rst_no && !done_o,
            "R2", {ctl_rst_no, phy_rst_no, ana_rst_no, dig_rst_no, done_o}, 0);
      for (int n = 1; n < 20000 && t_done < 0; n++) begin
         start_i = (n == inj);
         if (chg && n == 2) begin
            dly_phy_i = 16'd50; dly_ctl_i = 16'd60;
            dly_ana_i = 16'd70; dly_dig_i = 16'd3000;
         end
         @(negedge clk);
         if (t_phy  < 0 && phy_rst_no == ALL1) t_phy  = n;
         if (t_ctl  < 0 && ctl_rst_no == ALL1) t_ctl  = n;
         if (t_ana  < 0 && ana_rst_no)         t_ana  = n;
         if (t_dig  < 0 && dig_rst_no)         t_dig  = n;
         if (t_done < 0 && done_o)             t_done = n;
         if (!(ctl_rst_no == '0 || ctl_rst_no == ALL1)) lane_bad = 1;
         if (!(phy_rst_no == '0 || phy_rst_no == ALL1)) lane_bad = 1;
         if ((ctl_rst_no[0] && !phy_rst_no[0]) || (dig_rst_no && !ana_rst_no)) order_bad = 1;
      end
      start_i = 1'b0;
      check(!lane_bad, "R11", lane_bad, 0);
      check(!order_bad, "R12", order_bad, 0);
   endtask

   task automatic expect_times(input int p, input int c, input int a, input int d,
                               input string tag);
      int ep, ec, ea, ed;
      ep = floor_of(p, 1);
      ec = ep + floor_of(c, 1);
      ea = ec + floor_of(a, 1);
      ed = ea + floor_of(d, MING);
      check(t_phy == ep,     {tag, " R3 phy"}, t_phy, ep);
      check(t_ctl == ec,     {tag, " R4 ctl"}, t_ctl, ec);
      check(t_ana == ea,     {tag, " R5 ana"}, t_ana, ea);
      check(t_dig == ed,     {tag, " R6 dig"}, t_dig, ed);
      check(t_done == ed + 1, {tag, " R7 done"}, t_done, ed + 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R1: held state during and after reset
      repeat (3) @(negedge clk);
      check(ctl_rst_no == '0 && phy_rst_no == '0 && !ana_rst_no && !dig_rst_no && !done_o,
            "R1 in reset", {ctl_rst_no, phy_rst_no, ana_rst_no, dig_rst_no, done_o}, 0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      check(ctl_rst_no == '0 && phy_rst_no == '0 && !ana_rst_no && !dig_rst_no && !done_o,
            "R1 idle", {ctl_rst_no, phy_rst_no, ana_rst_no, dig_rst_no, done_o}, 0);

      // table walk: R3..R7, R10 (zero entry), R6 floor (short dig entry)
      for (int i = 0; i < 4; i++) begin
         run_seq(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], -1, 0);
         expect_times(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], $sformatf("vec%0d", i));
      end

      // R7: done and releases persist without a new start
      repeat (50) @(negedge clk);
      check(done_o && ctl_rst_no == ALL1 && phy_rst_no == ALL1 && ana_rst_no && dig_rst_no,
            "R7 hold", done_o, 1);

      // R8: start during the controller wait is ignored
      run_seq(10, 10, 10, 1000, 15, 0);
      expect_times(10, 10, 10, 1000, "R8 mid-ctl");
      // R8: start during the digital wait is ignored
      run_seq(4, 4, 4, 1100, 500, 0);
      expect_times(4, 4, 4, 1100, "R8 mid-dig");

      // R9: delay inputs changed after capture have no effect
      run_seq(4, 6, 8, 1000, -1, 1);
      expect_times(4, 6, 8, 1000, "R9");

      // R10: zero counts with a larger digital gap
      run_seq(0, 3, 0, 1500, -1, 0);
      expect_times(0, 3, 0, 1500, "R10");

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule